// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Unit

This unit is an execute-stage datapath slice. Two 32-bit source words each give up one signed 16-bit half. Each word has its own top/bottom select. The two halves are multiplied into a full 32-bit signed product. In product mode that product is the result. In accumulate mode the product is added to a third 32-bit word, and the 32-bit sum is the result. The sum wraps and is never saturated.

The result is registered and appears one clock after an enabled edge, together with a valid strobe. A sticky overflow flag records any signed overflow of the accumulate addition. The unit never lowers the flag by itself. Only the separate clear input lowers it, and a set in the same cycle wins over the clear. No other status flag is produced.

Top module: `half_mac`

## Requirements
- R1: With `selA` low the A half is `opA[15:0]`; with `selA` high it is `opA[31:16]`. The selected half is read as a 16-bit two's-complement value.
- R2: `selB` picks the half of `opB` in the same way (low = bits [15:0], high = bits [31:16]), independently of `selA`.
- R3: With `accMode` low, an enabled edge loads `result` with the exact 32-bit signed product of the two halves. The case -32768 × -32768 gives 32'h4000_0000.
- R4: With `accMode` high, an enabled edge loads `result` with (product + `opC`) modulo 2^32, with no saturation.
- R5: An enabled accumulate in which the product and `opC` share a sign bit but the sum's sign bit differs sets `stickyOvf` on that edge.
- R6: A product-mode operation, or an accumulate without overflow, never raises `stickyOvf`.
- R7: Once high, `stickyOvf` stays high until `flagClr` is sampled high on an edge. `flagClr` acts whether `execEn` is high or not.
- R8: When an overflowing accumulate and `flagClr` fall on the same edge, `stickyOvf` ends high.
- R9: On an edge with `execEn` low, `result` keeps its value, and `stickyOvf` keeps its value unless it is cleared.
- R10: `resultValid` is high in exactly the cycle after each edge with `execEn` high.
- R11: After reset, `result` is 0, `resultValid` is 0 and `stickyOvf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Execute enable; the operation is taken on this edge |
| accMode | input | 1 | 0 = product only, 1 = product plus opC |
| selA | input | 1 | Half select for opA (0 bottom, 1 top) |
| selB | input | 1 | Half select for opB (0 bottom, 1 top) |
| opA | input | 32 | First multiplicand source word |
| opB | input | 32 | Second multiplicand source word |
| opC | input | 32 | Accumulate addend |
| flagClr | input | 1 | Clears stickyOvf; a set on the same edge wins |
| result | output | 32 | Registered result |
| resultValid | output | 1 | High the cycle after an enabled edge |
| stickyOvf | output | 1 | Sticky accumulate-overflow flag |

## Verification
The bench drives all four select combinations on words whose halves differ in sign. A swapped or unsigned half extraction would then show up as a wrong magnitude or sign. It drives the -32768 × -32768 product. A design that treats that product as an overflow, or truncates it, would raise the flag or return the wrong value. Accumulates are pushed past both the positive and the negative limit. A design that saturates would return a clamped value instead of the wrapped sum, and a wrong overflow rule would miss the flag or raise it falsely. The bench also issues a clear with the enable low, and a clear on the same edge as an overflow. A clear gated by the enable, or a clear that beats the set, would leave the flag in the wrong state.

// File: rtl/half_mac_pkg.sv
package half_mac_pkg;

  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic loadRes;   // capture a new result
    logic accumEn;   // add the accumulate word and allow a flag set
    logic clearOvf;  // request to lower the sticky flag
  } mac_strobe_t;

endpackage

// File: rtl/half_mac_ctrl.sv
module half_mac_ctrl
  import half_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        execEn,
  input  logic        accMode,
  input  logic        flagClr,
  output mac_strobe_t strobe,
  output logic        resultValid
);

  always_comb begin
    strobe.loadRes  = execEn;
    strobe.accumEn  = execEn & accMode;
    strobe.clearOvf = flagClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= execEn;
  end

endmodule

// File: rtl/half_mac_dpath.sv
module half_mac_dpath
  import half_mac_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  mac_strobe_t   strobe,
  input  logic          selA,
  input  logic          selB,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] opC,
  output logic [DW-1:0] result,
  output logic          stickyOvf
);

  logic [DW-1:0] srcWord [2];
  logic          srcSel  [2];
  logic [DW-1:0] halfExt [2];

  assign srcWord[0] = opA;
  assign srcWord[1] = opB;
  assign srcSel[0]  = selA;
  assign srcSel[1]  = selB;

  // One half picker per multiplicand, each sign-extended to full width
  for (genvar i = 0; i < 2; i++) begin : g_pick
    logic [HW-1:0] halfRaw;
    assign halfRaw    = srcSel[i] ? srcWord[i][DW-1:HW] : srcWord[i][HW-1:0];
    assign halfExt[i] = {{(DW-HW){halfRaw[HW-1]}}, halfRaw};
  end

  logic signed [DW-1:0] product;
  logic [DW-1:0]        sum;
  logic                 addOvf;
  logic [DW-1:0]        nextRes;

  assign product = $signed(halfExt[0]) * $signed(halfExt[1]);
  assign sum     = product + opC;
  assign addOvf  = (product[DW-1] == opC[DW-1]) && (sum[DW-1] != product[DW-1]);
  assign nextRes = strobe.accumEn ? sum : product;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.loadRes) begin
      result <= nextRes;
    end
  end

  // A set wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyOvf <= 1'b0;
    end else if (strobe.accumEn && addOvf) begin
      stickyOvf <= 1'b1;
    end else if (strobe.clearOvf) begin
      stickyOvf <= 1'b0;
    end
  end

endmodule

// File: rtl/half_mac.sv
module half_mac
  import half_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic              accMode,
  input  logic              selA,
  input  logic              selB,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic              flagClr,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              stickyOvf
);

  mac_strobe_t strobe;

  half_mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .execEn(execEn), .accMode(accMode),
    .flagClr(flagClr), .strobe(strobe), .resultValid(resultValid)
  );

  half_mac_dpath #(.DW(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selA(selA), .selB(selB),
    .opA(opA), .opB(opB), .opC(opC), .result(result), .stickyOvf(stickyOvf)
  );

endmodule

// File: rtl/half_mac_chk.sv
module half_mac_chk
  import half_mac_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              execEn,
  input logic              accMode,
  input logic              selA,
  input logic              selB,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] opC,
  input logic              flagClr,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic              stickyOvf
);

  // Widened arithmetic, so overflow shows up as a range test
  logic signed [HALF_W-1:0] hA, hB;
  logic signed [47:0]       wideProd, wideSum;
  logic                     wideOvf;

  assign hA       = selA ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
  assign hB       = selB ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];
  assign wideProd = 48'(hA) * 48'(hB);
  assign wideSum  = wideProd + 48'($signed(opC));
  assign wideOvf  = (wideSum > 48'sh0000_7FFF_FFFF) || (wideSum < -48'sh0000_8000_0000);

  AST_VALID_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> resultValid);                                                     // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> !resultValid);                                                   // R10
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> $stable(result));                                                // R9
  AST_MUL_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && !accMode) |=> (result == $past(wideProd[DATA_W-1:0])));           // R3
  AST_ACC_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && accMode) |=> (result == $past(wideSum[DATA_W-1:0])));             // R4
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && accMode && wideOvf) |=> stickyOvf);                               // R5 R8
  AST_NO_FALSE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!stickyOvf && !(execEn && accMode && wideOvf)) |=> !stickyOvf);             // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stickyOvf && !flagClr) |=> stickyOvf);                                      // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !(execEn && accMode && wideOvf)) |=> !stickyOvf);                // R7

endmodule

bind half_mac half_mac_chk u_chk (
  .clk(clk), .rstN(rstN), .execEn(execEn), .accMode(accMode), .selA(selA),
  .selB(selB), .opA(opA), .opB(opB), .opC(opC), .flagClr(flagClr),
  .result(result), .resultValid(resultValid), .stickyOvf(stickyOvf)
);

// File: tb/half_mac_bench.sv
module half_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execEn = 0, accMode = 0, selA = 0, selB = 0, flagClr = 0;
  logic [31:0] opA = 0, opB = 0, opC = 0;
  logic [31:0] result;
  logic        resultValid, stickyOvf;

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference state
  logic [31:0] mRes = 0;
  logic        mValid = 0, mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  half_mac u_half_mac (
    .clk(clk), .rstN(rstN), .execEn(execEn), .accMode(accMode), .selA(selA),
    .selB(selB), .opA(opA), .opB(opB), .opC(opC), .flagClr(flagClr),
    .result(result), .resultValid(resultValid), .stickyOvf(stickyOvf)
  );

  function automatic longint pickHalf(logic [31:0] w, logic s);
    logic signed [15:0] h;
    h = s ? w[31:16] : w[15:0];
    return longint'(h);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " result"}, result, mRes);
    check({tag, " valid"}, 32'(resultValid), 32'(mValid));
    check({tag, " flag"}, 32'(stickyOvf), 32'(mFlag));
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge
  task automatic cyc(string tag, logic en, logic md, logic sa, logic sb,
                     logic [31:0] a, logic [31:0] b, logic [31:0] c, logic clr);
    longint prod, sum;
    logic ovf;
    execEn = en; accMode = md; selA = sa; selB = sb;
    opA = a; opB = b; opC = c; flagClr = clr;
    prod = pickHalf(a, sa) * pickHalf(b, sb);
    sum  = md ? prod + longint'($signed(c)) : prod;
    ovf  = md && (sum > 64'sd2147483647 || sum < -64'sd2147483648);
    @(posedge clk);
    if (en) mRes = sum[31:0];
    mValid = en;
    mFlag  = (en && ovf) ? 1'b1 : (clr ? 1'b0 : mFlag);
    #1;
    checkAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R11 reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R11 after release");

    // R1 R2: halves differ in sign: A top=-2 bottom=3, B top=5 bottom=-7
    cyc("R1 R2 sel BB", 1, 0, 0, 0, 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    cyc("R1 R2 sel TB", 1, 0, 1, 0, 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    cyc("R1 R2 sel BT", 1, 0, 0, 1, 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    cyc("R1 R2 sel TT", 1, 0, 1, 1, 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    // R3 R6: largest product, no flag
    cyc("R3 R6 min x min", 1, 0, 0, 1, 32'h0000_8000, 32'h8000_0000, 0, 0);
    // R10 R9: idle cycle holds the result
    cyc("R9 R10 idle hold", 0, 1, 1, 1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 0);
    // R4 R6: accumulate without overflow
    cyc("R4 R6 acc no ovf", 1, 1, 0, 0, 32'h0000_0010, 32'h0000_FFFF, 32'h0000_0100, 0);
    // R5: positive overflow, wraps
    cyc("R4 R5 acc pos ovf", 1, 1, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0);
    // R7: flag stays through unrelated ops
    cyc("R7 sticky mul", 1, 0, 0, 0, 32'h2, 32'h3, 0, 0);
    cyc("R7 sticky acc", 1, 1, 0, 0, 32'h2, 32'h3, 32'h5, 0);
    cyc("R7 sticky idle", 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 R9: clear while idle; result unchanged
    cyc("R7 R9 clear idle", 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: negative overflow: -32768*32767 + 0x80000000
    cyc("R5 acc neg ovf", 1, 1, 0, 0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 0);
    cyc("R7 clear enabled mul", 1, 0, 0, 0, 32'h4, 32'h4, 0, 1);
    // R8: overflow and clear on one edge
    cyc("R8 set beats clear", 1, 1, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 1);
    // R6: multiply with clear pending does not set
    cyc("R6 clear then mul", 1, 0, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1);
    cyc("R6 mul no set", 1, 0, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 0);

    for (int i = 0; i < 400; i++) begin
      cyc("R1 R2 R3 R4 R5 R7 R9 R10 random", ($urandom % 4) != 0, $urandom % 2,
          $urandom % 2, $urandom % 2, $urandom, $urandom, $urandom,
          ($urandom % 8) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule